// File: doc/BRIEF.md
# Interrupt Line Source Selector

This block sits between the general-purpose pin banks of a chip and its external interrupt controller. It receives the live levels of nine pin ports of sixteen pins each and produces sixteen interrupt-line levels. Each interrupt line has a run-time programmable 4-bit source field. The field chooses the port whose pin of the same number drives that line. Line 5 can therefore follow pin 5 of any one port, but never a pin with another number.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a word address inside a 0x400-byte window and combinational read data. The four source registers each hold four 4-bit fields in their low half. Two further registers exist only as read-as-zero placeholders. A compensation-control word stores whatever is written to it. The routing itself is purely combinational, so a new source choice reaches the line as soon as the register is updated. Edge detection, masking and pending state are left to the downstream controller.

Top module: `pin_irq_router`

## Requirements
- R1: A synchronous active-low reset clears every register to 0x00000000. After reset, every line n follows pin n of port 0 (`pin_in[n]`).
- R2: Line n equals `pin_in[16*s + n]`, where s is the value of that line's source field and s is 0 to 8.
- R3: The source field of line n sits at byte offset 0x08 + 4*(n/4), in bits [4*(n%4)+3 : 4*(n%4)]. Line 9, for example, uses bits [7:4] at 0x10.
- R4: A source field value from 9 to 15 drives its line low, whatever the pin levels are.
- R5: A write to a source register (0x08, 0x0C, 0x10, 0x14) stores only bits [15:0]. Bits [31:16] read back as zero.
- R6: Writes to offsets 0x00 and 0x04 are ignored, and both offsets always read 0x00000000.
- R7: The compensation-control register at 0x20 stores all 32 written bits and reads them back unchanged.
- R8: Reads from any other offset in the window (for example 0x18, 0x1C, 0x24, 0x3FC) return zero. Writes to those offsets change no register and no line.
- R9: Address bits [1:0] are ignored. Offset 0x23 reaches the register at 0x20, and 0x0E reaches 0x0C.
- R10: A write takes effect at the rising clock edge where `wr_en` is high. Before that edge the lines keep their old routing. Right after the edge they use the new routing.
- R11: Read data follows the address combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | 10 | Byte address inside the 0x400 window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 144 | Pin levels; bit 16*p + k is pin k of port p |
| line_out | output | 16 | Interrupt line levels |

## Verification
The bench targets the source-field codes 9 to 15. A design that indexed past the last port there would pass X or a neighbouring pin instead of a low level. It writes all-ones words to every register class, which exposes a source register that keeps its upper half or a placeholder that accepts data. It also checks that writes to holes in the window leave every register and line alone. A decoder that folds addresses would overwrite a live register in that case. Finally, it samples the lines just before and just after a write edge and moves the address between reads with no clock, which catches a routing or read path that was wrongly registered.

// File: rtl/pir_pkg.sv
// Package: shared decode constants for the interrupt line source selector.
// Assumes a 32-bit word-addressed register window; constants are word indices.
package pir_pkg;
    localparam int REMAP_WORD    = 0;   // placeholder, read-as-zero
    localparam int PMODE_WORD    = 1;   // placeholder, read-as-zero
    localparam int SEL_BASE_WORD = 2;   // first source-field register
    localparam int COMP_WORD     = 8;   // compensation-control word

    typedef enum logic [2:0] {
        RK_NONE,
        RK_REMAP,
        RK_PMODE,
        RK_SEL,
        RK_COMP
    } reg_kind_e;
endpackage

// File: rtl/pir_line_mux.sv
// Module: picks one port's pin for a single interrupt line.
// Assumes col_i[p] is this line's pin of port p; codes >= NUM_PORTS give 0.
module pir_line_mux #(
    parameter int NUM_PORTS = 9,
    parameter int SEL_W     = 4
) (
    input  logic [NUM_PORTS-1:0] col_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 line_o
);
    // Priority-free one-of-N pick; unmatched codes fall through to low.
    always_comb begin
        line_o = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel_i == SEL_W'(p)) line_o = col_i[p];
        end
    end
endmodule

// File: rtl/pir_regbank.sv
// Module: register storage, write masking and read decode.
// Assumes byte addressing with bits [1:0] ignored; reads are combinational.
module pir_regbank
    import pir_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 32,
    parameter int NUM_SEL_REGS = 4,
    parameter int SEL_REG_BITS = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [DATA_W-1:0]                    rd_data,
    output logic [NUM_SEL_REGS*SEL_REG_BITS-1:0] sel_flat
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int IDX_W  = (NUM_SEL_REGS > 1) ? $clog2(NUM_SEL_REGS) : 1;

    logic [WORD_W-1:0]       word;
    logic                    unused_byte_lanes;
    reg_kind_e               kind;
    logic [IDX_W-1:0]        sel_idx;
    logic [SEL_REG_BITS-1:0] sel_q [NUM_SEL_REGS];
    logic [DATA_W-1:0]       comp_q;

    assign word              = addr[ADDR_W-1:2];
    assign unused_byte_lanes = ^addr[1:0];

    // Classify the addressed word and derive the source-register index.
    always_comb begin
        kind    = RK_NONE;
        sel_idx = '0;
        if (word == WORD_W'(REMAP_WORD)) begin
            kind = RK_REMAP;
        end else if (word == WORD_W'(PMODE_WORD)) begin
            kind = RK_PMODE;
        end else if (word >= WORD_W'(SEL_BASE_WORD) &&
                     word <  WORD_W'(SEL_BASE_WORD + NUM_SEL_REGS)) begin
            kind    = RK_SEL;
            sel_idx = IDX_W'(word - WORD_W'(SEL_BASE_WORD));
        end else if (word == WORD_W'(COMP_WORD)) begin
            kind = RK_COMP;
        end
    end

    // Store writes; source registers keep only their low field bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_SEL_REGS; r++) sel_q[r] <= '0;
            comp_q <= '0;
        end else if (wr_en) begin
            case (kind)
                RK_SEL:  sel_q[sel_idx] <= wr_data[SEL_REG_BITS-1:0];
                RK_COMP: comp_q         <= wr_data;
                default: ;
            endcase
        end
    end

    // Return the addressed register; placeholders and holes read zero.
    always_comb begin
        case (kind)
            RK_SEL:  rd_data = DATA_W'(sel_q[sel_idx]);
            RK_COMP: rd_data = comp_q;
            default: rd_data = '0;
        endcase
    end

    for (genvar r = 0; r < NUM_SEL_REGS; r++) begin : g_flat
        assign sel_flat[r*SEL_REG_BITS +: SEL_REG_BITS] = sel_q[r];
    end

    // R5
    sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_SEL) |-> (rd_data[DATA_W-1:SEL_REG_BITS] == '0));

    // R6
    placeholder_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_REMAP || kind == RK_PMODE) |-> (rd_data == '0));

    // R7
    comp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_COMP) |=> (comp_q == $past(wr_data)));

    // R8
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (kind == RK_NONE || kind == RK_REMAP || kind == RK_PMODE))
        |=> ($stable(sel_flat) && $stable(comp_q)));

    // R8
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_NONE) |-> (rd_data == '0));
endmodule

// File: rtl/pin_irq_router.sv
// Module: top of the interrupt line source selector.
// Assumes pin_in bit p*NUM_LINES+k is pin k of port p; routing is combinational.
module pin_irq_router #(
    parameter int NUM_PORTS    = 9,
    parameter int NUM_LINES    = 16,
    parameter int SEL_W        = 4,
    parameter int SELS_PER_REG = 4,
    parameter int ADDR_W       = 10,
    parameter int DATA_W       = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data,
    input  logic [NUM_PORTS*NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0]           line_out
);
    localparam int SEL_REG_BITS = SELS_PER_REG * SEL_W;
    localparam int NUM_SEL_REGS = NUM_LINES / SELS_PER_REG;

    logic [NUM_SEL_REGS*SEL_REG_BITS-1:0] sel_flat;

    pir_regbank #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .NUM_SEL_REGS (NUM_SEL_REGS),
        .SEL_REG_BITS (SEL_REG_BITS)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sel_flat (sel_flat)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic [NUM_PORTS-1:0] col;

        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
            assign col[p] = pin_in[p*NUM_LINES + n];
        end

        pir_line_mux #(
            .NUM_PORTS (NUM_PORTS),
            .SEL_W     (SEL_W)
        ) mux_i (
            .col_i  (col),
            .sel_i  (sel_flat[n*SEL_W +: SEL_W]),
            .line_o (line_out[n])
        );

        // R4
        sel_range_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel_flat[n*SEL_W +: SEL_W]) >= NUM_PORTS) |-> !line_out[n]);
    end
endmodule

// File: tb/pin_irq_router_tb_top.sv
`timescale 1ns/1ps
module pin_irq_router_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [9:0]   addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic [143:0] pin_in = '0;
    logic [15:0]  line_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pin_irq_router dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .pin_in   (pin_in),
        .line_out (line_out)
    );

    typedef struct packed {
        logic [9:0]  a;
        logic [31:0] w;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{10'h008, 32'hDEAD_1234, 32'h0000_1234, 8'd5},  // R5
        '{10'h00C, 32'hFFFF_FFFF, 32'h0000_FFFF, 8'd5},  // R5
        '{10'h010, 32'h1234_8765, 32'h0000_8765, 8'd5},  // R5
        '{10'h014, 32'hABCD_0000, 32'h0000_0000, 8'd5},  // R5
        '{10'h020, 32'hCAFE_F00D, 32'hCAFE_F00D, 8'd7},  // R7
        '{10'h000, 32'hFFFF_FFFF, 32'h0000_0000, 8'd6},  // R6
        '{10'h004, 32'h1234_5678, 32'h0000_0000, 8'd6},  // R6
        '{10'h018, 32'hFFFF_FFFF, 32'h0000_0000, 8'd8},  // R8
        '{10'h3FC, 32'h0000_FFFF, 32'h0000_0000, 8'd8},  // R8
        '{10'h023, 32'h0000_0055, 32'h0000_0055, 8'd9}   // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [143:0] pattern(input int seed);
        logic [143:0] v;
        for (int i = 0; i < 144; i++) v[i] = (((i * 5 + seed * 3) % 7) < 3);
        return v;
    endfunction

    function automatic logic [15:0] model(input logic [143:0] pins, input logic [63:0] sels);
        logic [15:0] e;
        for (int n = 0; n < 16; n++) begin
            int s;
            s = int'(sels[4*n +: 4]);
            e[n] = (s < 9) ? pins[s*16 + n] : 1'b0;
        end
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_reset_state(input string tag);
        logic [31:0] got;
        for (int k = 0; k < 9; k++) begin
            rd(10'(4 * k), got);
            chk(tag, got, 32'h0);
        end
        #1 chk(tag, {16'h0, line_out}, {16'h0, pin_in[15:0]});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [63:0] sels;

        // R1: reset state, lines follow port 0
        pin_in = pattern(1);
        do_reset();
        check_reset_state("R1");

        // Table walk: write then read back at the same address
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].a, VEC[v].w);
            rd(VEC[v].a, got);
            chk($sformatf("R%0d vec %0d", VEC[v].req, v), got, VEC[v].e);
        end

        // R2 / R3: routing for several source maps and pin patterns
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 16; n++) sels[4*n +: 4] = 4'((n * (m + 5) + 2) % 9);
            for (int r = 0; r < 4; r++) wr(10'(8 + 4 * r), {16'h0, sels[16*r +: 16]});
            for (int pt = 0; pt < 3; pt++) begin
                @(negedge clk);
                pin_in = pattern(pt + 2 + 4 * m);
                #1 chk("R2 routing", {16'h0, line_out}, {16'h0, model(pin_in, sels)});
            end
        end

        // R3: one field only (line 9 at 0x10 bits [7:4]) selects port 3
        for (int r = 0; r < 4; r++) wr(10'(8 + 4 * r), 32'h0);
        @(negedge clk);
        pin_in = '0;
        pin_in[48 +: 16] = 16'hFFFF;
        wr(10'h010, 32'h0000_0030);
        #1 chk("R3 field position", {16'h0, line_out}, 32'h0000_0200);

        // R4: codes 9..15 force low even with all pins high
        @(negedge clk);
        pin_in = '1;
        wr(10'h008, 32'h0000_9ABC);
        wr(10'h00C, 32'h0000_FEDF);
        wr(10'h010, 32'h0000_8888);
        wr(10'h014, 32'h0000_0009);
        #1 chk("R4 out-of-range codes", {16'h0, line_out}, 32'h0000_EF00);

        // R10: not before the write edge, immediately after it
        @(negedge clk);
        addr = 10'h008; wr_data = 32'h0; wr_en = 1'b1;
        #1 chk("R10 before edge", {16'h0, line_out}, 32'h0000_EF00);
        @(posedge clk);
        #1 chk("R10 after edge", {16'h0, line_out}, 32'h0000_EF0F);
        @(negedge clk);
        wr_en = 1'b0;

        // R8: hole writes touch nothing
        wr(10'h018, 32'hFFFF_FFFF);
        wr(10'h01C, 32'hFFFF_FFFF);
        wr(10'h024, 32'hFFFF_FFFF);
        wr(10'h3FC, 32'hFFFF_FFFF);
        rd(10'h008, got); chk("R8 0x08 kept", got, 32'h0);
        rd(10'h00C, got); chk("R8 0x0C kept", got, 32'h0000_FEDF);
        rd(10'h020, got); chk("R8 0x20 kept", got, 32'h0000_0055);
        rd(10'h01C, got); chk("R8 hole read", got, 32'h0);
        #1 chk("R8 lines kept", {16'h0, line_out}, 32'h0000_EF0F);

        // R9: low address bits ignored
        rd(10'h00E, got); chk("R9 0x0E", got, 32'h0000_FEDF);

        // R11: read follows address with no clock edge
        @(negedge clk);
        addr = 10'h00C;
        #1 chk("R11 comb read a", rd_data, 32'h0000_FEDF);
        addr = 10'h020;
        #1 chk("R11 comb read b", rd_data, 32'h0000_0055);

        // R1: reset again after activity
        do_reset();
        check_reset_state("R1 second reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule